// File: doc/BRIEF.md
# Host Command to Display Bridge

This block sits between a host serial receiver and a display serial transmitter. The receiver hands it one byte at a time. The bridge reads those bytes as a two-byte command protocol: an opcode byte, then a parameter byte. It emits only the bytes that the display should see, each tagged as a display command or as display data.

One opcode forwards its parameter byte as a display command. Another opcode treats its parameter as a byte count and then forwards exactly that many following bytes as display data. The opcode and parameter bytes of a bulk transfer never reach the display. Any other opcode consumes its parameter and produces nothing.

The output is a single registered slot with a valid/ready handshake. When that slot is stalled, input bytes that would need it are held back, so no byte is lost. Header bytes are never stalled. A status pair reports whether a bulk transfer is running and how many data bytes are still owed.

Top module: `hostcmd_display_bridge`

## Requirements
- R1: Synchronous active-high reset leaves out_valid=0, bulk_active=0, bulk_left=0 and makes the next accepted byte an opcode, even in the middle of a bulk transfer.
- R2: After opcode 0x04, the next accepted byte appears on out_byte with out_is_data=0.
- R3: Opcode bytes, the parameter of opcode 0x06 and the parameters of unknown opcodes never appear at the output.
- R4: After opcode 0x06 with a length N from 1 to 255, the next N accepted bytes appear in order with out_is_data=1. The byte after them is taken as an opcode.
- R5: in_byte[0] carries the first bit received on the host link, and opcodes are compared in that orientation. For example, 0x20 is an unknown opcode and not 0x04.
- R6: A length of 0 after opcode 0x06 forwards nothing, and the next byte is taken as an opcode.
- R7: Any opcode other than 0x04 and 0x06 consumes exactly one parameter byte, whatever its value, and forwards nothing.
- R8: When out_valid=1 and out_ready=0, in_ready=0 whenever the next byte would be forwarded. Every forwarded byte is delivered exactly once.
- R9: While out_valid=1 and out_ready=0, out_valid, out_byte and out_is_data hold their values in the next cycle.
- R10: bulk_active=1 exactly while bulk data bytes are owed, and bulk_left equals that count. bulk_left is 0 when no transfer is running.
- R11: in_ready=1 whenever the next byte is an opcode, a length or a parameter that is not forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Host byte available |
| in_byte | input | 8 | Host byte, bit 0 received first |
| in_ready | output | 1 | Bridge accepts the host byte this cycle |
| out_valid | output | 1 | Display byte available |
| out_byte | output | 8 | Display byte |
| out_is_data | output | 1 | 1 = display data, 0 = display command |
| out_ready | input | 1 | Transmitter takes the display byte |
| bulk_active | output | 1 | A bulk data transfer is running |
| bulk_left | output | 8 | Bulk data bytes still owed |

## Verification
The hardest case to reach is a stalled output slot at the moment a forwarded byte arrives. This must hold the input back, while header bytes in the same stream still flow. The bench drives long random command streams under varying output stall rates, including a phase with heavy stalls during a 255-byte bulk transfer. Directed sequences add a zero length, a reset in the middle of a bulk transfer, an unknown opcode whose parameter is 0x06, and the bit-reversed form of the command opcode.

// File: rtl/hcb_pkg.sv
package hcb_pkg;
  typedef enum logic [2:0] {
    PS_OPCODE,
    PS_CMD_ARG,
    PS_LEN,
    PS_DISCARD,
    PS_BULK
  } parse_st_t;
endpackage

// File: rtl/hcb_bit_order.sv
module hcb_bit_order #(
  parameter int DW      = 8,
  parameter bit REVERSE = 1'b0
) (
  input  logic [DW-1:0] raw,
  output logic [DW-1:0] norm
);
  generate
    if (REVERSE) begin : g_rev
      for (genvar i = 0; i < DW; i++) begin : g_bit
        assign norm[i] = raw[DW-1-i];
      end
    end else begin : g_pass
      assign norm = raw;
    end
  endgenerate
endmodule

// File: rtl/hcb_parser.sv
module hcb_parser
  import hcb_pkg::*;
#(
  parameter int          DW      = 8,
  parameter logic [DW-1:0] OP_CMD  = 8'h04,
  parameter logic [DW-1:0] OP_BULK = 8'h06
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] byte_in,
  input  logic          fire,
  output logic          need_slot,
  output logic          fwd,
  output logic          fwd_data,
  output logic          bulk_active,
  output logic [DW-1:0] bulk_left
);
  parse_st_t     st;
  logic [DW-1:0] cnt;

  always_comb begin
    need_slot   = (st == PS_CMD_ARG) || (st == PS_BULK);
    fwd         = fire && need_slot;
    fwd_data    = (st == PS_BULK);
    bulk_active = (st == PS_BULK);
    bulk_left   = cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= PS_OPCODE;
      cnt <= '0;
    end else if (fire) begin
      case (st)
        PS_OPCODE: begin
          if (byte_in == OP_CMD)       st <= PS_CMD_ARG;
          else if (byte_in == OP_BULK) st <= PS_LEN;
          else                         st <= PS_DISCARD;
        end
        PS_CMD_ARG: st <= PS_OPCODE;
        PS_LEN: begin
          if (byte_in == '0) begin
            st <= PS_OPCODE;
          end else begin
            cnt <= byte_in;
            st  <= PS_BULK;
          end
        end
        PS_DISCARD: st <= PS_OPCODE;
        PS_BULK: begin
          cnt <= cnt - 1'b1;
          if (cnt == {{(DW-1){1'b0}}, 1'b1}) st <= PS_OPCODE;
        end
        default: st <= PS_OPCODE;
      endcase
    end
  end

  AST_LEFT_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !bulk_active |-> (bulk_left == '0)); // R10
  AST_LEFT_NONZERO: assert property (@(posedge clk) disable iff (rst)
    bulk_active |-> (bulk_left != '0)); // R10
  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
    (bulk_active && fire) |=> (bulk_left == $past(bulk_left) - 1'b1)); // R4
endmodule

// File: rtl/hcb_out_slot.sv
module hcb_out_slot #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] load_byte,
  input  logic          load_data,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_byte,
  output logic          out_is_data,
  output logic          slot_free
);
  assign slot_free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_byte    <= '0;
      out_is_data <= 1'b0;
    end else if (load) begin
      out_valid   <= 1'b1;
      out_byte    <= load_byte;
      out_is_data <= load_data;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) && $stable(out_is_data))); // R9
endmodule

// File: rtl/hostcmd_display_bridge.sv
module hostcmd_display_bridge #(
  parameter int          DW           = 8,
  parameter logic [DW-1:0] OP_CMD       = 8'h04,
  parameter logic [DW-1:0] OP_BULK      = 8'h06,
  parameter bit          RX_MSB_FIRST = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_byte,
  output logic          in_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_byte,
  output logic          out_is_data,
  input  logic          out_ready,
  output logic          bulk_active,
  output logic [DW-1:0] bulk_left
);
  logic [DW-1:0] norm_byte;
  logic          need_slot, fwd, fwd_data, slot_free, fire;

  hcb_bit_order #(.DW(DW), .REVERSE(RX_MSB_FIRST)) u_order (
    .raw (in_byte),
    .norm(norm_byte)
  );

  assign in_ready = !need_slot || slot_free;
  assign fire     = in_valid && in_ready;

  hcb_parser #(.DW(DW), .OP_CMD(OP_CMD), .OP_BULK(OP_BULK)) u_parser (
    .clk        (clk),
    .rst        (rst),
    .byte_in    (norm_byte),
    .fire       (fire),
    .need_slot  (need_slot),
    .fwd        (fwd),
    .fwd_data   (fwd_data),
    .bulk_active(bulk_active),
    .bulk_left  (bulk_left)
  );

  hcb_out_slot #(.DW(DW)) u_slot (
    .clk        (clk),
    .rst        (rst),
    .load       (fwd),
    .load_byte  (norm_byte),
    .load_data  (fwd_data),
    .out_ready  (out_ready),
    .out_valid  (out_valid),
    .out_byte   (out_byte),
    .out_is_data(out_is_data),
    .slot_free  (slot_free)
  );

  AST_BACKPRESSURE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && bulk_active) |-> !in_ready); // R8
  AST_FREE_SLOT_READY: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready); // R11
endmodule

// File: tb/test_hostcmd_display_bridge.sv
module test_hostcmd_display_bridge;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       in_ready;
  logic       out_valid;
  logic [7:0] out_byte;
  logic       out_is_data;
  logic       out_ready = 1'b0;
  logic       bulk_active;
  logic [7:0] bulk_left;

  hostcmd_display_bridge i_hostcmd_display_bridge (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
    .out_valid(out_valid), .out_byte(out_byte), .out_is_data(out_is_data),
    .out_ready(out_ready), .bulk_active(bulk_active), .bulk_left(bulk_left)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int n_out  = 0;
  int stall_pct = 0;
  bit took = 0;
  bit held = 0;
  logic [8:0] held_val;
  logic [8:0] expq[$];
  int m_st  = 0; // 0 opcode, 1 cmd arg, 2 len, 3 discard, 4 bulk
  int m_cnt = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic bit fwd_state(input int s);
    return (s == 1) || (s == 4);
  endfunction

  task automatic model_step(input logic [7:0] b);
    case (m_st)
      0: m_st = (b == 8'h04) ? 1 : (b == 8'h06) ? 2 : 3;
      1: begin expq.push_back({1'b0, b}); m_st = 0; end
      2: if (b == 8'h00) m_st = 0; else begin m_cnt = b; m_st = 4; end
      3: m_st = 0;
      default: begin
        expq.push_back({1'b1, b});
        m_cnt--;
        if (m_cnt == 0) m_st = 0;
      end
    endcase
  endtask

  always @(negedge clk) begin
    out_ready = ($urandom_range(99) >= stall_pct);
  end

  always @(negedge clk) begin
    #1;
    if (rst) begin
      took = 0;
      held = 0;
    end else begin
      if (held) check(out_valid && {out_is_data, out_byte} == held_val, "R9 stall hold",
                      {out_is_data, out_byte}, held_val);
      held = out_valid && !out_ready;
      held_val = {out_is_data, out_byte};
      if (out_valid && out_ready) begin
        n_out++;
        if (expq.size() == 0) begin
          check(1'b0, "R3 unexpected output", {out_is_data, out_byte}, 0);
        end else begin
          logic [8:0] e;
          e = expq.pop_front();
          check({out_is_data, out_byte} == e, e[8] ? "R4 data byte" : "R2 command byte",
                {out_is_data, out_byte}, e);
        end
      end
      check(bulk_active == (m_st == 4) && bulk_left == m_cnt[7:0], "R10 status",
            {bulk_active, bulk_left}, {(m_st == 4), m_cnt[7:0]});
      if (fwd_state(m_st) && out_valid && !out_ready)
        check(!in_ready, "R8 backpressure", in_ready, 0);
      if (!fwd_state(m_st))
        check(in_ready, "R11 header ready", in_ready, 1);
      took = in_valid && in_ready;
      if (took) model_step(in_byte);
    end
  end

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
    do @(posedge clk); while (!took);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic drain();
    int save = stall_pct;
    stall_pct = 0;
    idle(1);
    for (int i = 0; i < 600 && (expq.size() != 0 || out_valid); i++) @(negedge clk);
    idle(2);
    check(expq.size() == 0, "R8 nothing lost", expq.size(), 0);
    stall_pct = save;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    expq.delete();
    m_st = 0;
    m_cnt = 0;
    #2;
    check(!out_valid && !bulk_active && bulk_left == 0, "R1 reset state",
          {out_valid, bulk_active, bulk_left}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int base;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    do_reset();
    check(in_ready, "R1 ready after reset", in_ready, 1);

    // R2 single command
    send_byte(8'h04); send_byte(8'hA5); drain();
    // R6 zero length, then a command
    base = n_out;
    send_byte(8'h06); send_byte(8'h00); send_byte(8'h04); send_byte(8'h3C); drain();
    check(n_out - base == 1, "R6 zero length forwards nothing", n_out - base, 1);
    // R4 short bulk
    base = n_out;
    send_byte(8'h06); send_byte(8'h03);
    send_byte(8'h04); send_byte(8'h06); send_byte(8'hFF); drain();
    check(n_out - base == 3, "R4 bulk count", n_out - base, 3);
    // R5 reversed opcode 0x20 is unknown
    base = n_out;
    send_byte(8'h20); send_byte(8'h04); send_byte(8'h04); send_byte(8'h11); drain();
    check(n_out - base == 1, "R5 bit order", n_out - base, 1);
    // R7 unknown opcode with 0x06 parameter
    base = n_out;
    send_byte(8'h05); send_byte(8'h06); send_byte(8'h04); send_byte(8'h22); drain();
    check(n_out - base == 1, "R7 unknown opcode", n_out - base, 1);
    // R1 reset mid bulk
    send_byte(8'h06); send_byte(8'h0A); send_byte(8'h01); send_byte(8'h02);
    idle(1);
    check(bulk_active && bulk_left == 8, "R10 mid bulk count", bulk_left, 8);
    do_reset();
    base = n_out;
    send_byte(8'h04); send_byte(8'h77); drain();
    check(n_out - base == 1, "R1 opcode after reset", n_out - base, 1);
    // R8 heavy stall over maximum length bulk
    stall_pct = 85;
    base = n_out;
    send_byte(8'h06); send_byte(8'hFF);
    for (int i = 0; i < 255; i++) send_byte(8'($urandom));
    drain();
    check(n_out - base == 255, "R4 max length", n_out - base, 255);
    // random streams
    for (int k = 0; k < 400; k++) begin
      int kind = $urandom_range(9);
      if (k % 50 == 0) stall_pct = $urandom_range(90);
      if (kind < 4) begin
        send_byte(8'h04); send_byte(8'($urandom));
      end else if (kind < 8) begin
        int len = (kind == 7) ? 0 : $urandom_range(1, 20);
        send_byte(8'h06); send_byte(8'(len));
        for (int i = 0; i < len; i++) send_byte(8'($urandom));
      end else begin
        logic [7:0] op;
        do op = 8'($urandom); while (op == 8'h04 || op == 8'h06);
        send_byte(op); send_byte(8'($urandom));
      end
      if ($urandom_range(3) == 0) idle($urandom_range(1, 3));
    end
    drain();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule